// File: doc/BRIEF.md
# Transmit Descriptor Walker

This block takes one transmit descriptor at a time and turns it into a short list of work. The descriptor holds a control word, a first buffer pointer and a third word. Depending on the control bits, that third word is either a second buffer pointer or the address of the following descriptor. The walker emits up to two buffer-fetch commands, each an address and a byte length. After those it presents the address of the next descriptor, so that an upstream fetcher can load that descriptor.

The descriptor arrives on a valid/ready handshake together with the address it was read from and the base address of the descriptor ring. Two linking schemes are supported:

- **Ring mode:** descriptors sit back to back in memory, and the last one in the ring is marked to wrap to the ring base.
- **Chained mode:** each descriptor carries an explicit pointer to its successor. That pointer must be 16-byte aligned. A misaligned pointer stops the walker until the next reset, and the walker does not follow it.

The status word of a descriptor is not interpreted here, and it does not enter the block.

Top module: `txdesc_walker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `desc_ready` is 1 and `cmd_valid`, `next_valid` and `align_err` are 0.
- R2: A nonzero first-buffer size, in `desc_ctrl[10:0]`, produces a command with `cmd_sel`=0, `cmd_addr`=`desc_buf1`, which may have any byte alignment, and `cmd_len` equal to that size.
- R3: When `desc_ctrl[10:0]` is zero, no command for buffer 1 is issued, and the walker goes straight to buffer 2 or to the next address.
- R4: When the walker is not in chained mode, a nonzero second-buffer size in `desc_ctrl[21:11]` produces a command with `cmd_sel`=1, `cmd_addr`=`desc_word3`, which may have any byte alignment, and `cmd_len` equal to that size. A zero size issues no buffer 2 command.
- R5: Chained mode is `desc_ctrl[24]`=1 with `desc_ctrl[25]`=0. In chained mode no buffer 2 command is issued, and `next_addr` equals `desc_word3`.
- R6: When `desc_ctrl[25]` (wrap) is 1, `desc_ctrl[24]` has no effect. `desc_word3` is treated as the buffer 2 pointer, `next_addr` equals `ring_base`, and the alignment of `desc_word3` is not checked.
- R7: With both bits 24 and 25 clear, `next_addr` equals `desc_addr` + 16, modulo 2^32.
- R8: Commands come in the order buffer 1, then buffer 2. Each command holds its address, length and select stable while `cmd_ready` is low. `next_valid` rises only after all commands have been taken, and `desc_ready` stays low until `next_addr` has been accepted.
- R9: In chained mode, a `desc_word3` with nonzero bits 3:0 sets `align_err` on the cycle after acceptance. The flag then stays set until reset. While it is set, no command or next address is issued and `desc_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| desc_valid | input | 1 | A descriptor is offered |
| desc_ready | output | 1 | The walker can accept a descriptor |
| desc_ctrl | input | 32 | Control word: sizes, chain bit and wrap bit |
| desc_buf1 | input | 32 | First buffer pointer |
| desc_word3 | input | 32 | Second buffer pointer, or next-descriptor pointer in chained mode |
| desc_addr | input | 32 | Address the descriptor was read from |
| ring_base | input | 32 | Base address of the descriptor ring |
| cmd_valid | output | 1 | A buffer-fetch command is presented |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_sel | output | 1 | 0 for buffer 1, 1 for buffer 2 |
| cmd_addr | output | 32 | Buffer start address |
| cmd_len | output | 11 | Buffer length in bytes |
| next_valid | output | 1 | The next-descriptor address is presented |
| next_ready | input | 1 | Upstream takes the next address |
| next_addr | output | 32 | Address of the next descriptor |
| align_err | output | 1 | Sticky flag for a misaligned chained pointer |

## Verification
The assertions check the handshake rules on every cycle:

- a command or next address is held stable while it waits;
- at most one of `desc_ready`, `cmd_valid` and `next_valid` is high at a time;
- `next_valid` is entered only from an accepted descriptor or an accepted command;
- the alignment flag is sticky and silences the walker while it is set.

Only the bench scenarios can show that the right buffers are chosen, with the right lengths and in the right number, for each combination of the chain and wrap bits and zero sizes. The same holds for the three sources of the next address and for the exemption of wrap descriptors from the alignment check.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;

  localparam int unsigned AW         = 32;  // address and word width
  localparam int unsigned LW         = 11;  // buffer length width
  localparam int unsigned LEN1_LSB   = 0;
  localparam int unsigned LEN2_LSB   = 11;
  localparam int unsigned CHAIN_BIT  = 24;
  localparam int unsigned WRAP_BIT   = 25;
  localparam int unsigned ALIGN_BITS = 4;   // chained pointer alignment
  localparam int unsigned DESC_BYTES = 16;  // ring stride

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUF1,
    ST_BUF2,
    ST_NEXT,
    ST_HALT
  } walk_st_e;

  typedef struct packed {
    logic [AW-1:0] b1_addr;
    logic [LW-1:0] b1_len;
    logic          b1_en;
    logic [AW-1:0] b2_addr;
    logic [LW-1:0] b2_len;
    logic          b2_en;
    logic [AW-1:0] nxt_addr;
    logic          bad_ptr;
  } walk_plan_t;

endpackage

// File: rtl/txdesc_rst_sync.sv
module txdesc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/txdesc_decode.sv
module txdesc_decode
  import txdesc_pkg::*;
#(
  parameter int unsigned ALIGN = ALIGN_BITS,
  parameter int unsigned STEP  = DESC_BYTES
) (
  input  logic [AW-1:0] ctrl,
  input  logic [AW-1:0] buf1_ptr,
  input  logic [AW-1:0] word3,
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] base_addr,
  output walk_plan_t    plan
);

  logic          chained;
  logic          wrap;
  logic [LW-1:0] len1;
  logic [LW-1:0] len2;
  logic          misaligned;

  assign wrap    = ctrl[WRAP_BIT];
  // the wrap bit overrides the chain bit
  assign chained = ctrl[CHAIN_BIT] & ~wrap;
  assign len1    = ctrl[LEN1_LSB +: LW];
  assign len2    = ctrl[LEN2_LSB +: LW];

  generate
    if (ALIGN > 0) begin : g_align_chk
      assign misaligned = |word3[ALIGN-1:0];
    end else begin : g_no_align_chk
      assign misaligned = 1'b0;
    end
  endgenerate

  always_comb begin
    plan.b1_addr = buf1_ptr;
    plan.b1_len  = len1;
    plan.b1_en   = |len1;
    plan.b2_addr = word3;
    plan.b2_len  = len2;
    plan.b2_en   = ~chained & (|len2);
    plan.bad_ptr = chained & misaligned;
    if (chained)   plan.nxt_addr = word3;
    else if (wrap) plan.nxt_addr = base_addr;
    else           plan.nxt_addr = cur_addr + AW'(STEP);
  end

endmodule

// File: rtl/txdesc_seq.sv
module txdesc_seq
  import txdesc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_valid,
  output logic          desc_ready,
  input  walk_plan_t    plan_in,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_sel,
  output logic [AW-1:0] cmd_addr,
  output logic [LW-1:0] cmd_len,
  output logic          next_valid,
  input  logic          next_ready,
  output logic [AW-1:0] next_addr,
  output logic          align_err
);

  walk_st_e   st_q, st_d;
  walk_plan_t plan_q;
  logic       accept;

  assign desc_ready = (st_q == ST_IDLE);
  assign accept     = desc_valid & desc_ready;

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (desc_valid) begin
        if (plan_in.bad_ptr)    st_d = ST_HALT;
        else if (plan_in.b1_en) st_d = ST_BUF1;
        else if (plan_in.b2_en) st_d = ST_BUF2;
        else                    st_d = ST_NEXT;
      end
      ST_BUF1: if (cmd_ready)  st_d = plan_q.b2_en ? ST_BUF2 : ST_NEXT;
      ST_BUF2: if (cmd_ready)  st_d = ST_NEXT;
      ST_NEXT: if (next_ready) st_d = ST_IDLE;
      ST_HALT: st_d = ST_HALT;
      default: st_d = ST_IDLE;
    endcase
  end

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // datapath register, enabled on acceptance only
  always_ff @(posedge clk) begin
    if (accept) plan_q <= plan_in;
  end

  assign cmd_valid  = (st_q == ST_BUF1) | (st_q == ST_BUF2);
  assign cmd_sel    = (st_q == ST_BUF2);
  assign cmd_addr   = cmd_sel ? plan_q.b2_addr : plan_q.b1_addr;
  assign cmd_len    = cmd_sel ? plan_q.b2_len  : plan_q.b1_len;
  assign next_valid = (st_q == ST_NEXT);
  assign next_addr  = plan_q.nxt_addr;
  assign align_err  = (st_q == ST_HALT);

  // R8: a waiting command keeps its contents
  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_sel));

  // R8: a waiting next address keeps its value
  a_r8_next_hold: assert property (@(posedge clk) disable iff (!rst_n)
    next_valid && !next_ready |=> next_valid && $stable(next_addr));

  // R8: only one handshake is open at a time
  a_r8_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({desc_ready, cmd_valid, next_valid}));

  // R8: next address follows an accepted descriptor or an accepted command
  a_r8_next_after_cmds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(next_valid) |-> $past(desc_valid && desc_ready) || $past(cmd_valid && cmd_ready));

  // R9: error flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> align_err);

  // R9: halted walker is silent
  a_r9_silent: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !desc_ready && !cmd_valid && !next_valid);

endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
  import txdesc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_valid,
  output logic          desc_ready,
  input  logic [AW-1:0] desc_ctrl,
  input  logic [AW-1:0] desc_buf1,
  input  logic [AW-1:0] desc_word3,
  input  logic [AW-1:0] desc_addr,
  input  logic [AW-1:0] ring_base,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_sel,
  output logic [AW-1:0] cmd_addr,
  output logic [LW-1:0] cmd_len,
  output logic          next_valid,
  input  logic          next_ready,
  output logic [AW-1:0] next_addr,
  output logic          align_err
);

  logic       rst_n_int;
  walk_plan_t plan;

  txdesc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  txdesc_decode #(.ALIGN(ALIGN_BITS), .STEP(DESC_BYTES)) u_decode (
    .ctrl      (desc_ctrl),
    .buf1_ptr  (desc_buf1),
    .word3     (desc_word3),
    .cur_addr  (desc_addr),
    .base_addr (ring_base),
    .plan      (plan)
  );

  txdesc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .plan_in    (plan),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_sel    (cmd_sel),
    .cmd_addr   (cmd_addr),
    .cmd_len    (cmd_len),
    .next_valid (next_valid),
    .next_ready (next_ready),
    .next_addr  (next_addr),
    .align_err  (align_err)
  );

endmodule

// File: tb/txdesc_walker_tb.sv
`timescale 1ns/1ps
module txdesc_walker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_valid = 1'b0;
  logic        desc_ready;
  logic [31:0] desc_ctrl = '0, desc_buf1 = '0, desc_word3 = '0, desc_addr = '0;
  logic [31:0] ring_base = 32'h4000_0000;
  logic        cmd_valid, cmd_ready = 1'b0, cmd_sel;
  logic [31:0] cmd_addr;
  logic [10:0] cmd_len;
  logic        next_valid, next_ready = 1'b0;
  logic [31:0] next_addr;
  logic        align_err;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;  // 250 MHz

  txdesc_walker u_dut (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_ctrl(desc_ctrl), .desc_buf1(desc_buf1), .desc_word3(desc_word3),
    .desc_addr(desc_addr), .ring_base(ring_base), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_sel(cmd_sel), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .next_valid(next_valid), .next_ready(next_ready), .next_addr(next_addr),
    .align_err(align_err)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] b1;
    logic [31:0] w3;
    logic [31:0] da;
  } vec_t;

  // ctrl layout: {6'rsvd, wrap, chain, 2'rsvd, len2, len1}
  localparam vec_t TBL [0:7] = '{
    '{ {6'd0,1'b0,1'b0,2'd0,11'd50,11'd100},   32'h1000_0003, 32'h2000_0001, 32'h8000_0000 },
    '{ {6'd0,1'b0,1'b0,2'd0,11'd7,11'd0},      32'h1111_1111, 32'h2222_2222, 32'h8000_0010 },
    '{ {6'd0,1'b0,1'b0,2'd0,11'd0,11'd2047},   32'h3000_0005, 32'h3333_3333, 32'h8000_0020 },
    '{ {6'd0,1'b0,1'b0,2'd0,11'd0,11'd0},      32'h4444_0000, 32'h5555_0000, 32'hFFFF_FFF0 },
    '{ {6'd0,1'b0,1'b1,2'd0,11'd9,11'd20},     32'h6000_0007, 32'h0000_4440, 32'h8000_0030 },
    '{ {6'd0,1'b0,1'b1,2'd0,11'd9,11'd0},      32'h6000_0100, 32'h0000_8880, 32'h8000_0040 },
    '{ {6'd0,1'b1,1'b1,2'd0,11'd3,11'd5},      32'h7000_0002, 32'h0000_5557, 32'h8000_0050 },
    '{ {6'd63,1'b1,1'b0,2'd3,11'd2047,11'd1},  32'h7100_0009, 32'h7200_000B, 32'h8000_00F0 }
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // starts and ends at a falling edge
  task automatic send(input vec_t v);
    desc_ctrl = v.ctrl; desc_buf1 = v.b1; desc_word3 = v.w3; desc_addr = v.da;
    desc_valid = 1'b1;
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk(desc_ready == 1'b1, "R1", "desc_ready in reset", 32'(desc_ready), 32'd1);
    chk(cmd_valid == 1'b0,  "R1", "cmd_valid in reset",  32'(cmd_valid), 32'd0);
    chk(next_valid == 1'b0, "R1", "next_valid in reset", 32'(next_valid), 32'd0);
    chk(align_err == 1'b0,  "R1", "align_err in reset",  32'(align_err), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    logic [31:0] ea [2];
    logic [10:0] el [2];
    logic        es [2];
    int          en;
    logic [31:0] enext;
    logic [31:0] ga [2];
    logic [10:0] gl [2];
    logic        gs [2];
    int          gn;
    bit          gotn;
    logic [31:0] gnext;
    bit          chained, wrap;
    bit          wait_prev;
    logic [31:0] prev_addr;
    // independent model of R2..R7
    wrap    = v.ctrl[25];
    chained = v.ctrl[24] && !wrap;
    en = 0;
    if (v.ctrl[10:0] != 0) begin ea[en] = v.b1; el[en] = v.ctrl[10:0]; es[en] = 1'b0; en++; end
    if (!chained && v.ctrl[21:11] != 0) begin ea[en] = v.w3; el[en] = v.ctrl[21:11]; es[en] = 1'b1; en++; end
    enext = chained ? v.w3 : (wrap ? ring_base : v.da + 32'd16);

    send(v);
    gn = 0; gotn = 1'b0; gnext = '0; wait_prev = 1'b0; prev_addr = '0;
    for (int c = 0; c < 40 && !gotn; c++) begin
      cmd_ready  = (c % 3) != 1;
      next_ready = (c % 2) == 1;
      if (wait_prev)
        chk(cmd_valid && cmd_addr == prev_addr, "R8", "stalled cmd held", cmd_addr, prev_addr);
      if (cmd_valid && desc_ready)
        chk(1'b0, "R8", "desc_ready while busy", 32'd1, 32'd0);
      wait_prev = cmd_valid && !cmd_ready;
      prev_addr = cmd_addr;
      if (cmd_valid && cmd_ready) begin
        if (gn < 2) begin ga[gn] = cmd_addr; gl[gn] = cmd_len; gs[gn] = cmd_sel; end
        gn++;
      end
      if (next_valid && next_ready) begin gotn = 1'b1; gnext = next_addr; end
      @(negedge clk);
    end
    cmd_ready = 1'b0; next_ready = 1'b0;

    chk(gn == en, (en == 2 || (!chained && v.ctrl[21:11] == 0)) ? "R4" : "R3",
        $sformatf("vec%0d cmd count", idx), 32'(gn), 32'(en));
    for (int k = 0; k < 2; k++) begin
      if (k < en && k < gn) begin
        chk(ga[k] == ea[k], es[k] ? "R4" : "R2", $sformatf("vec%0d cmd%0d addr", idx, k), ga[k], ea[k]);
        chk(gl[k] == el[k], es[k] ? "R4" : "R2", $sformatf("vec%0d cmd%0d len", idx, k), 32'(gl[k]), 32'(el[k]));
        chk(gs[k] == es[k], "R8", $sformatf("vec%0d cmd%0d order", idx, k), 32'(gs[k]), 32'(es[k]));
      end
    end
    chk(gotn && gnext == enext, chained ? "R5" : (wrap ? "R6" : "R7"),
        $sformatf("vec%0d next addr", idx), gnext, enext);
    chk(align_err == 1'b0, wrap ? "R6" : "R9", $sformatf("vec%0d no align err", idx),
        32'(align_err), 32'd0);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    foreach (TBL[i]) run_vec(i, TBL[i]);

    // R9: misaligned chained pointer halts the walker
    send('{ {6'd0,1'b0,1'b1,2'd0,11'd0,11'd64}, 32'h9000_0000, 32'h0000_1234, 32'h8000_0100 });
    chk(align_err == 1'b1,  "R9", "align_err set", 32'(align_err), 32'd1);
    chk(desc_ready == 1'b0, "R9", "desc_ready low when halted", 32'(desc_ready), 32'd0);
    cmd_ready = 1'b1; next_ready = 1'b1; desc_valid = 1'b1;
    for (int c = 0; c < 10; c++) begin
      if (cmd_valid || next_valid || desc_ready || !align_err)
        chk(1'b0, "R9", "halt not silent/sticky",
            {28'd0, cmd_valid, next_valid, desc_ready, align_err}, 32'h1);
      @(negedge clk);
    end
    chk(align_err == 1'b1, "R9", "align_err sticky", 32'(align_err), 32'd1);
    cmd_ready = 1'b0; next_ready = 1'b0; desc_valid = 1'b0;

    // reset clears the halt and the walker runs again
    do_reset();
    run_vec(8, TBL[0]);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule